// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Sequencer

This block decides, once per clock, whether the core must enter privileged mode, and performs the entry. A synchronous exception arrives as a valid strobe with a cause code and an argument byte. Asynchronous requests arrive on four level lines, which are filtered by the current interrupt priority level (IPL). When an entry is taken, the block computes an entry offset, adds it to the privileged base register, and registers the result as the new PC. It also saves the return address with the previous mode flag folded into bit 0 and sets the privileged-mode flag. All of this happens on a single clock edge.

The block also renames general register numbers while privileged mode is active. A small set of register numbers is steered to an eight-entry shadow bank, so that privileged code can use scratch registers without saving them. The register file and instruction decode sit outside this block. A mode-exit strobe from the return path clears the privileged flag.

Top module: `exc_entry_seq`

## Requirements
- R1: While `priv_o` is 1, no interrupt request is accepted, whatever the request lines and IPL are.
- R2: Request line k is eligible only when the IPL is at most 3+k. The lines are bit 0 device, bit 1 clock, bit 2 inter-processor and bit 3 machine check, so at IPL 7 nothing is eligible.
- R3: Among eligible lines the highest bit wins. The taken cause codes are 1 machine check, 2 inter-processor, 3 clock and 4 device, and `err_code_o` is written 0 on an interrupt entry.
- R4: Cause codes 0 to 9 (0 reset, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic, 9 FP disabled, plus 1 to 4 as in R3) use entry offset code*0x80. A synchronous entry writes `exc_arg_i` into `err_code_o`.
- R5: Cause code 10 is a call gate with number n = `exc_arg_i`. If bit 7 of n is set, the offset is 0x2000 + (n-0x80)*64. Otherwise it is 0x1000 + n*64.
- R6: On entry, `saved_pc_o` becomes `pc_i` ORed with the privileged flag held before the edge, placed in bit 0.
- R7: On entry, `entry_pc_o` becomes `base_i` plus the offset, `cause_o` takes the cause, `priv_o` becomes 1 and `entry_valid_o` is 1 for that cycle only. All of these update on the same edge.
- R8: A synchronous cause code of 11 to 15 pulses `bad_code_o` for one cycle. It leaves `entry_pc_o`, `saved_pc_o`, `cause_o` and `err_code_o` unchanged and does not assert `entry_valid_o`.
- R9: When `exc_valid_i` is 1, the synchronous exception is handled and all interrupt requests are ignored that cycle.
- R10: With the privileged flag set, register numbers 8 to 14 map to shadow entries 0 to 6 and register 25 maps to shadow entry 7 (`reg_shadow_o`=1). Every other number, and every number outside privileged mode, passes through unchanged. The result is registered one cycle after `reg_idx_i`.
- R11: `mode_exit_i` clears `priv_o` on the next edge, unless an entry is taken on that same edge, in which case `priv_o` stays 1.
- R12: After synchronous reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 4 | Interrupt request levels: device, clock, inter-processor, machine check |
| ipl_i | input | 3 | Current interrupt priority level |
| exc_valid_i | input | 1 | Synchronous exception strobe |
| exc_code_i | input | 4 | Synchronous cause code |
| exc_arg_i | input | 8 | Error code, or call-gate number for code 10 |
| pc_i | input | 64 | PC of the faulting or interrupted instruction |
| base_i | input | 64 | Privileged entry base register |
| mode_exit_i | input | 1 | Return from privileged mode |
| reg_idx_i | input | 5 | Architectural register number to remap |
| entry_valid_o | output | 1 | Entry taken on the last edge |
| entry_pc_o | output | 64 | New PC of the last entry |
| saved_pc_o | output | 64 | Return address with previous mode in bit 0 |
| priv_o | output | 1 | Privileged-mode flag |
| cause_o | output | 4 | Cause code of the last entry |
| err_code_o | output | 8 | Error code of the last entry |
| bad_code_o | output | 1 | Unknown synchronous cause rejected |
| reg_shadow_o | output | 1 | Remapped register lies in the shadow bank |
| reg_map_o | output | 5 | Remapped register index |

## Verification
Several rules are checked by the assertions on every cycle. Interrupts are never taken from privileged mode, and a taken interrupt respects the IPL threshold. Entry always leaves the flag set with a cleared error code for interrupts. The new PC keeps the base register's low six bits, and a rejected code leaves the entry PC alone. Exact offsets, the call-gate split, the ordering of the four lines and the shadow numbering need concrete values, so they are shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 4;
  localparam int ARG_W  = 8;
  localparam int N_IRQ  = 4;

  typedef enum logic [CODE_W-1:0] {
    EX_RESET = 4'd0,
    EX_MCHK  = 4'd1,
    EX_IPI   = 4'd2,
    EX_CLK   = 4'd3,
    EX_DEV   = 4'd4,
    EX_MMF   = 4'd5,
    EX_ALIGN = 4'd6,
    EX_OPC   = 4'd7,
    EX_ARITH = 4'd8,
    EX_FPOFF = 4'd9,
    EX_GATE  = 4'd10
  } exc_code_e;

  // Number of causes served from the fixed stride table (codes 0..N_FIXED-1).
  localparam int N_FIXED = 10;
endpackage

// File: rtl/irq_select.sv
module irq_select #(
  parameter int N_LINES = 4,
  parameter int IPL_W   = 3,
  parameter int LOW_LVL = 3,
  localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic [IPL_W-1:0]   ipl_i,
  input  logic               block_i,
  output logic               hit_o,
  output logic [LINE_W-1:0]  line_o
);
  logic [N_LINES-1:0] elig;

  // Line g is open while the level is at or below LOW_LVL+g.
  for (genvar g = 0; g < N_LINES; g++) begin : g_elig
    assign elig[g] = req_i[g] && !block_i && (int'(ipl_i) <= LOW_LVL + g);
  end

  // Scan upward; the last eligible line seen is the most urgent.
  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i]) begin
        hit_o  = 1'b1;
        line_o = LINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/entry_vector.sv
module entry_vector
  import exc_entry_pkg::*;
#(
  parameter int             PC_W      = 64,
  parameter int             STRIDE_LG = 7,
  parameter int             SLOT_LG   = 6,
  parameter logic [PC_W-1:0] SYS_GATE  = 'h1000,
  parameter logic [PC_W-1:0] USR_GATE  = 'h2000
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [ARG_W-1:0]  arg_i,
  output logic              known_o,
  output logic [PC_W-1:0]   off_o
);
  logic [PC_W-1:0] slot_off;

  assign slot_off = PC_W'(arg_i[ARG_W-2:0]) << SLOT_LG;

  always_comb begin
    known_o = 1'b0;
    off_o   = '0;
    if (int'(code_i) < N_FIXED) begin
      known_o = 1'b1;
      off_o   = PC_W'(code_i) << STRIDE_LG;
    end else if (code_i == EX_GATE) begin
      known_o = 1'b1;
      off_o   = (arg_i[ARG_W-1] ? USR_GATE : SYS_GATE) + slot_off;
    end
  end
endmodule

// File: rtl/shadow_map.sv
module shadow_map #(
  parameter int IDX_W = 5,
  parameter int FIRST = 8,
  parameter int LAST  = 14,
  parameter int EXTRA = 25
) (
  input  logic             priv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             shadow_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] EXTRA_SLOT = IDX_W'(LAST - FIRST + 1);

  always_comb begin
    shadow_o = 1'b0;
    idx_o    = idx_i;
    if (priv_i) begin
      if (int'(idx_i) >= FIRST && int'(idx_i) <= LAST) begin
        shadow_o = 1'b1;
        idx_o    = idx_i - IDX_W'(FIRST);
      end else if (int'(idx_i) == EXTRA) begin
        shadow_o = 1'b1;
        idx_o    = EXTRA_SLOT;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int IPL_W = 3,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic [IPL_W-1:0]  ipl_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [ARG_W-1:0]  exc_arg_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   base_i,
  input  logic              mode_exit_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  output logic              entry_valid_o,
  output logic [PC_W-1:0]   entry_pc_o,
  output logic [PC_W-1:0]   saved_pc_o,
  output logic              priv_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [ARG_W-1:0]  err_code_o,
  output logic              bad_code_o,
  output logic              reg_shadow_o,
  output logic [IDX_W-1:0]  reg_map_o
);
  localparam int LINE_W = $clog2(N_IRQ);

  logic              irq_hit;
  logic [LINE_W-1:0] irq_line;
  logic [CODE_W-1:0] irq_code;
  logic [CODE_W-1:0] sel_code;
  logic              vec_known;
  logic [PC_W-1:0]   vec_off;
  logic              take;
  logic              map_shadow;
  logic [IDX_W-1:0]  map_idx;

  irq_select #(
    .N_LINES (N_IRQ),
    .IPL_W   (IPL_W),
    .LOW_LVL (3)
  ) i_irq_select (
    .req_i   (irq_req_i),
    .ipl_i   (ipl_i),
    .block_i (priv_o | exc_valid_i),
    .hit_o   (irq_hit),
    .line_o  (irq_line)
  );

  // Line k maps to cause N_IRQ-k: the top line gets the lowest code.
  assign irq_code = CODE_W'(N_IRQ) - CODE_W'(irq_line);
  assign sel_code = exc_valid_i ? exc_code_i : irq_code;

  entry_vector #(
    .PC_W (PC_W)
  ) i_entry_vector (
    .code_i  (sel_code),
    .arg_i   (exc_arg_i),
    .known_o (vec_known),
    .off_o   (vec_off)
  );

  shadow_map #(
    .IDX_W (IDX_W)
  ) i_shadow_map (
    .priv_i   (priv_o),
    .idx_i    (reg_idx_i),
    .shadow_o (map_shadow),
    .idx_o    (map_idx)
  );

  assign take = exc_valid_i ? vec_known : irq_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_valid_o <= 1'b0;
      entry_pc_o    <= '0;
      saved_pc_o    <= '0;
      priv_o        <= 1'b0;
      cause_o       <= '0;
      err_code_o    <= '0;
      bad_code_o    <= 1'b0;
      reg_shadow_o  <= 1'b0;
      reg_map_o     <= '0;
    end else begin
      entry_valid_o <= take;
      bad_code_o    <= exc_valid_i && !vec_known;
      reg_shadow_o  <= map_shadow;
      reg_map_o     <= map_idx;
      if (take) begin
        entry_pc_o <= base_i + vec_off;
        saved_pc_o <= pc_i | PC_W'(priv_o);
        priv_o     <= 1'b1;
        cause_o    <= sel_code;
        err_code_o <= exc_valid_i ? exc_arg_i : '0;
      end else if (mode_exit_i) begin
        priv_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int IPL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [IPL_W-1:0]  ipl_i,
  input logic              exc_valid_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [PC_W-1:0]   base_i,
  input logic              entry_valid_o,
  input logic [PC_W-1:0]   entry_pc_o,
  input logic [PC_W-1:0]   saved_pc_o,
  input logic              priv_o,
  input logic [CODE_W-1:0] cause_o,
  input logic [ARG_W-1:0]  err_code_o,
  input logic              bad_code_o,
  input logic              reg_shadow_o,
  input logic [4:0]        reg_map_o
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R1: an entry without a synchronous strobe needs user mode beforehand.
  a_r1_no_irq_in_priv: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (entry_valid_o && !$past(exc_valid_i)) |-> !$past(priv_o));

  // R2: a taken interrupt was open at the level seen on that edge.
  a_r2_ipl_gate: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (entry_valid_o && !$past(exc_valid_i)) |->
      (int'(cause_o) >= 1 && int'(cause_o) <= 4 &&
       int'($past(ipl_i)) + int'(cause_o) <= 7));

  // R3: interrupt entries clear the error code.
  a_r3_err_cleared: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (entry_valid_o && !$past(exc_valid_i)) |-> err_code_o == '0);

  // R6: saved bit 0 carries the previous mode.
  a_r6_saved_mode: assert property (@(posedge clk) disable iff (rst || !past_ok)
    entry_valid_o |-> saved_pc_o[0] == ($past(pc_i[0]) | $past(priv_o)));

  // R7: entry sets the flag and keeps the base's low six bits.
  a_r7_entry_state: assert property (@(posedge clk) disable iff (rst || !past_ok)
    entry_valid_o |-> (priv_o && entry_pc_o[5:0] == $past(base_i[5:0])));

  // R8: a rejected code never moves the entry PC.
  a_r8_bad_no_change: assert property (@(posedge clk) disable iff (rst || !past_ok)
    bad_code_o |-> (!entry_valid_o && $stable(entry_pc_o) && $stable(cause_o)));

  // R9: a synchronous entry reports the strobed code.
  a_r9_sync_wins: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (entry_valid_o && $past(exc_valid_i)) |-> cause_o == $past(exc_code_i));

  // R10: shadow indices stay inside the eight-entry bank.
  a_r10_shadow_range: assert property (@(posedge clk) disable iff (rst || !past_ok)
    reg_shadow_o |-> reg_map_o < 5'd8);

  // R11: the flag only rises through an entry.
  a_r11_priv_rise: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(priv_o) |-> entry_valid_o);
endmodule

bind exc_entry_seq exc_entry_chk #(.PC_W(PC_W), .IPL_W(IPL_W)) i_exc_entry_chk (
  .clk           (clk),
  .rst           (rst),
  .ipl_i         (ipl_i),
  .exc_valid_i   (exc_valid_i),
  .exc_code_i    (exc_code_i),
  .pc_i          (pc_i),
  .base_i        (base_i),
  .entry_valid_o (entry_valid_o),
  .entry_pc_o    (entry_pc_o),
  .saved_pc_o    (saved_pc_o),
  .priv_o        (priv_o),
  .cause_o       (cause_o),
  .err_code_o    (err_code_o),
  .bad_code_o    (bad_code_o),
  .reg_shadow_o  (reg_shadow_o),
  .reg_map_o     (reg_map_o)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_req_i = '0;
  logic [2:0]  ipl_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [3:0]  exc_code_i = '0;
  logic [7:0]  exc_arg_i = '0;
  logic [63:0] pc_i = '0;
  logic [63:0] base_i = '0;
  logic        mode_exit_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic        entry_valid_o, priv_o, bad_code_o, reg_shadow_o;
  logic [63:0] entry_pc_o, saved_pc_o;
  logic [3:0]  cause_o;
  logic [7:0]  err_code_o;
  logic [4:0]  reg_map_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic        m_valid = 0, m_priv = 0, m_bad = 0, m_shadow = 0;
  logic [63:0] m_pc = 0, m_saved = 0;
  logic [3:0]  m_cause = 0;
  logic [7:0]  m_err = 0;
  logic [4:0]  m_map = 0;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .ipl_i(ipl_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i), .exc_arg_i(exc_arg_i),
    .pc_i(pc_i), .base_i(base_i), .mode_exit_i(mode_exit_i), .reg_idx_i(reg_idx_i),
    .entry_valid_o(entry_valid_o), .entry_pc_o(entry_pc_o), .saved_pc_o(saved_pc_o),
    .priv_o(priv_o), .cause_o(cause_o), .err_code_o(err_code_o),
    .bad_code_o(bad_code_o), .reg_shadow_o(reg_shadow_o), .reg_map_o(reg_map_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2/R3: eligibility threshold 3+line, highest line wins, cause 4-line.
  function automatic int pick_irq(logic [3:0] req, logic [2:0] ipl);
    for (int ln = 3; ln >= 0; ln--)
      if (req[ln] && int'(ipl) <= 3 + ln) return 4 - ln;
    return -1;
  endfunction

  // R4/R5: entry offsets
  function automatic logic [63:0] entry_off(int code, logic [7:0] n);
    if (code < 10) return 64'(code) * 64'h80;
    if (n[7]) return 64'h2000 + 64'(n - 8'h80) * 64;
    return 64'h1000 + 64'(n) * 64;
  endfunction

  task automatic model_step();
    int code;
    logic taken, from_irq;
    taken = 0; from_irq = 0; code = -1;
    m_bad = 0;
    if (exc_valid_i) begin
      if (int'(exc_code_i) <= 10) begin taken = 1; code = int'(exc_code_i); end
      else m_bad = 1;                                   // R8
    end else if (!m_priv) begin                          // R1
      code = pick_irq(irq_req_i, ipl_i);
      if (code >= 0) begin taken = 1; from_irq = 1; end
    end
    // R10 uses the mode before the edge
    m_shadow = 0; m_map = reg_idx_i;
    if (m_priv && reg_idx_i >= 8 && reg_idx_i <= 14) begin m_shadow = 1; m_map = reg_idx_i - 8; end
    else if (m_priv && reg_idx_i == 25) begin m_shadow = 1; m_map = 7; end
    m_valid = taken;
    if (taken) begin
      m_pc    = base_i + entry_off(code, exc_arg_i);     // R7
      m_saved = pc_i | 64'(m_priv);                      // R6
      m_cause = 4'(code);
      m_err   = from_irq ? 8'h00 : exc_arg_i;            // R3 / R4
      m_priv  = 1;
    end else if (mode_exit_i) m_priv = 0;                // R11
  endtask

  task automatic cycle(logic ev, logic [3:0] code, logic [7:0] arg, logic [3:0] req,
                       logic [2:0] ipl, logic [63:0] pc, logic [63:0] base,
                       logic ex, logic [4:0] ridx);
    @(negedge clk);
    exc_valid_i = ev; exc_code_i = code; exc_arg_i = arg; irq_req_i = req;
    ipl_i = ipl; pc_i = pc; base_i = base; mode_exit_i = ex; reg_idx_i = ridx;
    model_step();
    @(posedge clk); #1;
    chk("R7 entry_valid", 64'(entry_valid_o), 64'(m_valid));
    chk("R7 entry_pc", entry_pc_o, m_pc);
    chk("R6 saved_pc", saved_pc_o, m_saved);
    chk("R11 priv", 64'(priv_o), 64'(m_priv));
    chk("R9 cause", 64'(cause_o), 64'(m_cause));
    chk("R3 err_code", 64'(err_code_o), 64'(m_err));
    chk("R8 bad_code", 64'(bad_code_o), 64'(m_bad));
    chk("R10 shadow", 64'(reg_shadow_o), 64'(m_shadow));
    chk("R10 map", 64'(reg_map_o), 64'(m_map));
  endtask

  task automatic idle(logic ex);
    cycle(0, 0, 0, 0, 0, 64'h0, 64'h0, ex, 0);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R12: reset state
    chk("R12 entry_valid", 64'(entry_valid_o), 0);
    chk("R12 entry_pc", entry_pc_o, 0);
    chk("R12 saved_pc", saved_pc_o, 0);
    chk("R12 priv", 64'(priv_o), 0);
    chk("R12 cause_err", {52'h0, cause_o, err_code_o}, 0);
    chk("R12 bad_map", {57'h0, bad_code_o, reg_shadow_o, reg_map_o}, 0);

    // R2: each line alone at every IPL
    for (int ln = 0; ln < 4; ln++)
      for (int lv = 0; lv < 8; lv++) begin
        cycle(0, 0, 0, 4'(1 << ln), 3'(lv), 64'h4000, 64'h8000_0000, 0, 0);
        chk("R2 eligibility", 64'(entry_valid_o), 64'(lv <= 3 + ln));
        idle(1);
      end

    // R3: all lines pending, machine check wins at IPL 6 and below
    cycle(0, 0, 0, 4'hF, 3'd2, 64'h100, 64'h10000, 0, 0);
    chk("R3 top line cause", 64'(cause_o), 64'd1);
    chk("R3 machine check vector", entry_pc_o, 64'h10080);
    idle(1);
    cycle(0, 0, 0, 4'h3, 3'd4, 64'h100, 64'h10000, 0, 0);
    chk("R3 clock over device", 64'(cause_o), 64'd3);
    idle(1);

    // R1: privileged mode blocks interrupts
    cycle(1, 4'd5, 8'h11, 0, 0, 64'h200, 64'h10000, 0, 0);
    chk("R4 memory fault vector", entry_pc_o, 64'h10280);
    cycle(0, 0, 0, 4'hF, 3'd0, 64'h300, 64'h10000, 0, 0);
    chk("R1 blocked in priv", 64'(entry_valid_o), 0);

    // R6: nested entry records the mode bit
    cycle(1, 4'd8, 8'h22, 0, 0, 64'h1230, 64'h10000, 0, 0);
    chk("R6 saved low bit", saved_pc_o, 64'h1231);

    // R5: call gates in both ranges
    cycle(1, 4'd10, 8'h85, 0, 0, 64'h40, 64'h10000, 0, 0);
    chk("R5 unprivileged gate", entry_pc_o, 64'h12140);
    cycle(1, 4'd10, 8'h05, 0, 0, 64'h40, 64'h10000, 0, 0);
    chk("R5 privileged gate", entry_pc_o, 64'h11140);

    // R10: shadow remap while privileged
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 5'd8);
    chk("R10 reg 8", {58'h0, reg_shadow_o, reg_map_o}, {58'h0, 1'b1, 5'd0});
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 5'd25);
    chk("R10 reg 25", {58'h0, reg_shadow_o, reg_map_o}, {58'h0, 1'b1, 5'd7});
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 5'd15);
    chk("R10 reg 15", {58'h0, reg_shadow_o, reg_map_o}, {58'h0, 1'b0, 5'd15});

    // R8: unknown code leaves entry state alone
    cycle(1, 4'd13, 8'h77, 0, 0, 64'h999, 64'h5000, 0, 0);
    chk("R8 bad pulse", 64'(bad_code_o), 1);
    chk("R8 pc kept", entry_pc_o, 64'h11140);

    // R11: exit and entry on one edge keeps privileged mode
    cycle(1, 4'd7, 8'h01, 0, 0, 64'h80, 64'h20000, 1, 0);
    chk("R11 entry beats exit", 64'(priv_o), 1);
    idle(1);
    chk("R11 exit clears", 64'(priv_o), 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 5'd8);
    chk("R10 user passthrough", {58'h0, reg_shadow_o, reg_map_o}, {58'h0, 1'b0, 5'd8});

    // R9: synchronous beats pending interrupt
    cycle(1, 4'd6, 8'h33, 4'hF, 3'd0, 64'h500, 64'h30000, 0, 0);
    chk("R9 sync cause", 64'(cause_o), 64'd6);
    idle(1);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 2000; it++) begin
      logic ev = ($urandom % 10) < 3;
      cycle(ev, 4'($urandom), 8'($urandom), 4'($urandom), 3'($urandom),
            {$urandom, $urandom & 32'hFFFF_FFFC}, {$urandom, $urandom},
            ($urandom % 4) == 0, 5'($urandom));
    end

    finish_run();
  end
endmodule